// File: doc/BRIEF.md
# Free-Running Microsecond Timer with Coherent Byte Readout

This block is a 12-bit up-counter that advances once per assertion of a 1 MHz tick enable, giving a time base with microsecond resolution. It wraps after 4096 ticks, so software can time intervals up to roughly 4 ms. The same counter drives two periodic interrupt pulses: one every 128 ticks and one every 1024 ticks.

Software reads the count through an 8-bit window with a one-bit select. A read of the low byte returns count bits 7:0. In the same cycle it copies count bits 11:8 into a holding nibble. A later read of the high byte returns that holding nibble, not the live upper bits. The two reads therefore form one consistent 12-bit sample, even when many ticks pass between them. Read data is registered and appears in the cycle after the read strobe.

Top module: `free_run_timer`

## Requirements
- R1: While `rst_ni` is low, the count and the holding nibble clear to zero, `rdata_o` reads 0 and both interrupt outputs are low.
- R2: Each clock edge with `tick_i` high adds one to the count. Edges with `tick_i` low leave the count unchanged.
- R3: The count wraps from 4095 to 0.
- R4: A read with `sel_hi_i`=0 puts the count bits 7:0 on `rdata_o` in the following cycle. The count used is the value before any tick in that same cycle.
- R5: A read with `sel_hi_i`=0 loads the holding nibble with count bits 11:8, taken from the same count value that supplies the returned low byte.
- R6: A read with `sel_hi_i`=1 puts the holding nibble on `rdata_o` bits 3:0 in the following cycle. Bits 7:4 read as zero.
- R7: The holding nibble changes only on a low-byte read. Ticks and high-byte reads leave it unchanged, so a high read with no earlier low read returns the reset or stale value.
- R8: `irq_128_o` is high for exactly one cycle after each tick that moves count bits 6:0 from 127 to 0, and is low at all other times.
- R9: `irq_1024_o` is high for exactly one cycle after each tick that moves count bits 9:0 from 1023 to 0, and is low at all other times.
- R10: `rdata_o` keeps its value in cycles that follow an edge with `rd_en_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 µs count enable |
| rd_en_i | input | 1 | Read strobe |
| sel_hi_i | input | 1 | Register select: 0 low byte, 1 high byte |
| rdata_o | output | 8 | Registered read data |
| irq_128_o | output | 1 | Pulse every 128 ticks |
| irq_1024_o | output | 1 | Pulse every 1024 ticks |

## Verification
The tests use four patterns: sparse ticks with idle gaps, a continuous tick run over a full 4096 wrap, a low-byte read in the same cycle as the tick that carries into bit 8, and high-byte reads with no low read before them. The gapped pattern separates "count on tick" from "count on every clock". The long run shows each interrupt firing only at its own binary boundary, and shows the wrap. The carry-cycle read shows whether the captured nibble is the pre-tick value or the post-tick value, and whether a high read returns the snapshot or the live bits. The stale high read shows that only a low read loads the holding nibble.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CNT_W   = 12;
  localparam int DATA_W  = 8;
  localparam int N_TAPS  = 2;
  localparam int TAP_W [N_TAPS] = '{7, 10};
endpackage

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o)); // R2
endmodule

// File: rtl/timer_irq_tap.sv
module timer_irq_tap #(
  parameter int TAP_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [TAP_W-1:0] cnt_low_i,
  output logic             irq_o
);
  // pulse lands in the cycle the low bits read zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= tick_i & (&cnt_low_i);
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R8 R9
  AST_IRQ_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt_low_i == '0); // R8 R9
endmodule

// File: rtl/timer_read_port.sv
module timer_read_port #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              sel_hi_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [HI_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      rdata_o <= '0;
    end else if (rd_en_i) begin
      if (sel_hi_i) begin
        rdata_o <= {{(DATA_W-HI_W){1'b0}}, hold_q};
      end else begin
        rdata_o <= cnt_i[DATA_W-1:0];
        hold_q  <= cnt_i[CNT_W-1:DATA_W];
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && !sel_hi_i) |=> $stable(hold_q)); // R7
  AST_HOLD_SNAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !sel_hi_i) |=> hold_q == $past(cnt_i[CNT_W-1:DATA_W])); // R5
  AST_HI_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel_hi_i) |=> rdata_o[DATA_W-1:HI_W] == '0); // R6
  AST_RDATA_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R10
endmodule

// File: rtl/free_run_timer.sv
module free_run_timer
  import timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rd_en_i,
  input  logic              sel_hi_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_128_o,
  output logic              irq_1024_o
);
  logic [CNT_W-1:0]  cnt;
  logic [N_TAPS-1:0] irq_v;

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .cnt_o(cnt)
  );

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    timer_irq_tap #(.TAP_W(TAP_W[g])) u_tap (
      .clk_i, .rst_ni, .tick_i,
      .cnt_low_i(cnt[TAP_W[g]-1:0]),
      .irq_o(irq_v[g])
    );
  end

  timer_read_port #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
    .clk_i, .rst_ni, .rd_en_i, .sel_hi_i, .cnt_i(cnt), .rdata_o
  );

  assign irq_128_o  = irq_v[0];
  assign irq_1024_o = irq_v[1];

  AST_IRQ_NESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_1024_o |-> irq_128_o); // R9
endmodule

// File: tb/sim_free_run_timer.sv
module sim_free_run_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, rd = 1'b0, sel = 1'b0;
  logic [7:0] rdata;
  logic       irq_a, irq_b;

  int total = 0, bad = 0;
  logic [11:0] m_cnt = '0;
  logic [3:0]  m_hold = '0;
  logic [7:0]  m_rd = '0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  free_run_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rd_en_i(rd), .sel_hi_i(sel),
    .rdata_o(rdata), .irq_128_o(irq_a), .irq_1024_o(irq_b)
  );

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample just after posedge
  task automatic cyc(bit t, bit r, bit s);
    bit e_a, e_b;
    @(negedge clk);
    tick = t; rd = r; sel = s;
    @(posedge clk);
    #1;
    e_a = t && (m_cnt[6:0] == 7'h7f);
    e_b = t && (m_cnt[9:0] == 10'h3ff);
    if (r) begin
      if (s) m_rd = {4'h0, m_hold};
      else begin
        m_rd = m_cnt[7:0];
        m_hold = m_cnt[11:8];
      end
    end
    if (t) m_cnt = m_cnt + 1'b1;
    chk("R8 irq_128", 12'(irq_a), 12'(e_a));
    chk("R9 irq_1024", 12'(irq_b), 12'(e_b));
    chk(r ? (s ? "R6 high read" : "R4 low read") : "R10 rdata hold", 12'(rdata), 12'(m_rd));
  endtask

  task automatic t_reset;
    #1;
    chk("R1 rdata", 12'(rdata), 12'h0);
    chk("R1 irq", 12'({irq_a, irq_b}), 12'h0);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 1, 1); // R1 hold cleared
    cyc(0, 1, 0); // R1 count cleared
  endtask

  task automatic t_gapped;
    for (int i = 0; i < 300; i++) cyc(i % 3 == 0, 0, 0);
    cyc(0, 1, 0); // R2 only ticked edges count
    cyc(0, 1, 1); // R5
  endtask

  task automatic t_coherent;
    while (m_cnt != 12'h2ff) cyc(1, 0, 0);
    cyc(1, 1, 0);  // R4 R5: read on carry tick returns ff, nibble 2
    for (int i = 0; i < 5; i++) cyc(1, 0, 0);
    cyc(1, 1, 1);  // R6: snapshot 2, live is 3
    chk("R5 snapshot nibble", 12'(rdata), 12'h2);
  endtask

  task automatic t_stale;
    for (int i = 0; i < 600; i++) cyc(1, 0, 0);
    cyc(0, 1, 1);  // R7 high read still returns old nibble
    chk("R7 stale hold", 12'(rdata), 12'h2);
    cyc(0, 1, 1);
  endtask

  task automatic t_wrap;
    int na = 0, nb = 0;
    for (int i = 0; i < 4200; i++) begin
      cyc(1, (i % 97) == 0, (i % 194) == 97);
      na += irq_a; nb += irq_b;
    end
    chk("R8 count of 128 pulses", 12'(na), 12'(33));
    chk("R9 count of 1024 pulses", 12'(nb), 12'(4));
    while (m_cnt != 12'hfff) cyc(1, 0, 0);
    cyc(1, 0, 0);
    cyc(0, 1, 0);
    chk("R3 wrap low", 12'(rdata), 12'h0);
    cyc(0, 1, 1);
    chk("R3 wrap high", 12'(rdata), 12'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_gapped();
    t_coherent();
    t_stale();
    t_wrap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule